// File: doc/BRIEF.md
# Capability Permission Filter

This block sits on the capability data path between the register file and the memory port. Each strobed request carries an operation code, the permissions of the authorizing capability and a data capability: its tag, a sealed flag, an object-type field, a permission field and an opaque payload (address and bounds bits). The block returns the capability that should land in the register file (on a load) or in memory (on a store), one cycle later.

On loads, a capability fetched through an authorizer that lacks the transitive-write permission is weakened. Its store rights are cleared, and so is that same transitive-write bit, so the restriction follows any chain of pointers. Sealed capabilities are exempt. A single reserved object-type code marks register-only (ephemeral) capabilities. An ordinary store of such a capability loses its tag, and a dedicated ephemeral-store operation produces the marked copy from a normal capability.

Top module: `cap_perm_filter`

## Requirements
- R1: While and right after reset, out_valid is 0 and out_tag, out_otype, out_perms and out_payload are all 0.
- R2: A request strobed with in_valid at one rising edge shows its result and out_valid=1 after that edge. With no strobe, out_valid is 0 and every result output holds its last value.
- R3: Operation codes are load=0, store=1, ephemeral-store=2 and reserved=3. With the default parameters the permission bits are store-data=2, store-capability=4, store-local=5 and transitive-write=7.
- R4: A load of a tagged, unsealed capability through an authorizer whose transitive-write bit is 0 clears the store-data, store-capability, store-local and transitive-write bits (mask 0x0B4). All other permission bits, the object type, the payload and the tag are unchanged.
- R5: A load through an authorizer whose transitive-write bit is 1 returns the capability unchanged, tag included.
- R6: A load of a sealed capability returns it unchanged even when the authorizer's transitive-write bit is 0.
- R7: A load of an untagged word returns all bits unchanged with tag 0, whatever the authorizer holds.
- R8: The ephemeral mark is object type EPH_OTYPE (default 14). A sealed flag on an ephemeral capability is ignored, so an ephemeral load is unchanged and tagged through a transitive-write authorizer and is weakened like R4 through one without it.
- R9: An ordinary store of an ephemeral capability outputs its bits unchanged with tag 0. An ordinary store of any other capability outputs bits and tag unchanged.
- R10: An ephemeral-store of a tagged, unsealed, non-ephemeral capability outputs tag 1, object type EPH_OTYPE, and unchanged permissions and payload.
- R11: An ephemeral-store whose source is untagged, sealed or already ephemeral outputs its bits unchanged with tag 0.
- R12: The reserved operation code outputs the bits unchanged with tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation code (R3) |
| auth_perms | input | PERM_W | Authorizing capability permissions |
| cap_tag | input | 1 | Data capability validity tag |
| cap_sealed | input | 1 | Data capability sealed flag |
| cap_otype | input | OTYPE_W | Data capability object type |
| cap_perms | input | PERM_W | Data capability permissions |
| cap_payload | input | PAY_W | Data capability remaining bits |
| out_valid | output | 1 | Result strobe |
| out_tag | output | 1 | Result tag |
| out_otype | output | OTYPE_W | Result object type |
| out_perms | output | PERM_W | Result permissions |
| out_payload | output | PAY_W | Result remaining bits |

## Verification
The clocked properties assume that every input is steady around the rising edge at which in_valid is sampled and that reset is applied before the first request. They also assume that the operation code is a real value and not X. The bench changes inputs only on falling edges and holds in_valid low during reset. It drives all four codes and keeps each request to a single cycle, so every property compares one output cycle against exactly one strobed input.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  typedef enum logic [1:0] {
    OP_LOAD      = 2'd0,
    OP_STORE     = 2'd1,
    OP_EPH_STORE = 2'd2,
    OP_RESERVED  = 2'd3
  } cpf_op_e;
endpackage

// File: rtl/cpf_load_path.sv
module cpf_load_path #(
  parameter int PERM_W  = 12,
  parameter int BIT_ST  = 2,
  parameter int BIT_SC  = 4,
  parameter int BIT_SLC = 5,
  parameter int BIT_TW  = 7
) (
  input  logic              auth_tw,
  input  logic              tag,
  input  logic              sealed_eff,
  input  logic [PERM_W-1:0] perms_i,
  output logic [PERM_W-1:0] perms_o
);
  localparam logic [PERM_W-1:0] STRIP_MASK =
      (PERM_W'(1) << BIT_ST) | (PERM_W'(1) << BIT_SC) |
      (PERM_W'(1) << BIT_SLC) | (PERM_W'(1) << BIT_TW);

  logic weaken;

  always_comb begin
    weaken  = tag && !auth_tw && !sealed_eff;
    perms_o = weaken ? (perms_i & ~STRIP_MASK) : perms_i;
  end
endmodule

// File: rtl/cpf_store_path.sv
module cpf_store_path #(
  parameter int OTYPE_W = 4,
  parameter logic [OTYPE_W-1:0] EPH_CODE = '1
) (
  input  logic               eph_op,
  input  logic               tag,
  input  logic               sealed_eff,
  input  logic               is_eph,
  input  logic [OTYPE_W-1:0] otype_i,
  output logic               tag_o,
  output logic [OTYPE_W-1:0] otype_o
);
  logic mark_ok;

  always_comb begin
    mark_ok = tag && !sealed_eff && !is_eph;
    if (eph_op) begin
      tag_o   = mark_ok;
      otype_o = mark_ok ? EPH_CODE : otype_i;
    end else begin
      tag_o   = tag && !is_eph;
      otype_o = otype_i;
    end
  end
endmodule

// File: rtl/cpf_out_reg.sv
module cpf_out_reg #(
  parameter int W = 49
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/cap_perm_filter.sv
module cap_perm_filter
  import cpf_pkg::*;
#(
  parameter int PERM_W    = 12,
  parameter int OTYPE_W   = 4,
  parameter int PAY_W     = 32,
  parameter int EPH_OTYPE = 14,
  parameter int BIT_ST    = 2,
  parameter int BIT_SC    = 4,
  parameter int BIT_SLC   = 5,
  parameter int BIT_TW    = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         op,
  input  logic [PERM_W-1:0]  auth_perms,
  input  logic               cap_tag,
  input  logic               cap_sealed,
  input  logic [OTYPE_W-1:0] cap_otype,
  input  logic [PERM_W-1:0]  cap_perms,
  input  logic [PAY_W-1:0]   cap_payload,
  output logic               out_valid,
  output logic               out_tag,
  output logic [OTYPE_W-1:0] out_otype,
  output logic [PERM_W-1:0]  out_perms,
  output logic [PAY_W-1:0]   out_payload
);
  localparam logic [OTYPE_W-1:0] EPH_CODE = OTYPE_W'(EPH_OTYPE);
  localparam int RES_W = 1 + OTYPE_W + PERM_W + PAY_W;
  localparam logic [PERM_W-1:0] STORE_BITS =
      (PERM_W'(1) << BIT_ST) | (PERM_W'(1) << BIT_SC) |
      (PERM_W'(1) << BIT_SLC) | (PERM_W'(1) << BIT_TW);

  cpf_op_e            op_e;
  logic               is_eph;
  logic               sealed_eff;
  logic               unused_auth;
  logic [PERM_W-1:0]  ld_perms;
  logic               st_tag;
  logic [OTYPE_W-1:0] st_otype;
  logic               nx_tag;
  logic [OTYPE_W-1:0] nx_otype;
  logic [PERM_W-1:0]  nx_perms;
  logic [RES_W-1:0]   res_q;

  assign op_e        = cpf_op_e'(op);
  assign is_eph      = (cap_otype == EPH_CODE);
  assign sealed_eff  = cap_sealed && !is_eph;
  assign unused_auth = ^auth_perms;

  cpf_load_path #(
    .PERM_W(PERM_W), .BIT_ST(BIT_ST), .BIT_SC(BIT_SC),
    .BIT_SLC(BIT_SLC), .BIT_TW(BIT_TW)
  ) ld_i (
    .auth_tw   (auth_perms[BIT_TW]),
    .tag       (cap_tag),
    .sealed_eff(sealed_eff),
    .perms_i   (cap_perms),
    .perms_o   (ld_perms)
  );

  cpf_store_path #(
    .OTYPE_W(OTYPE_W), .EPH_CODE(EPH_CODE)
  ) st_i (
    .eph_op    (op_e == OP_EPH_STORE),
    .tag       (cap_tag),
    .sealed_eff(sealed_eff),
    .is_eph    (is_eph),
    .otype_i   (cap_otype),
    .tag_o     (st_tag),
    .otype_o   (st_otype)
  );

  always_comb begin
    nx_tag   = 1'b0;
    nx_otype = cap_otype;
    nx_perms = cap_perms;
    case (op_e)
      OP_LOAD: begin
        nx_tag   = cap_tag;
        nx_perms = ld_perms;
      end
      OP_STORE, OP_EPH_STORE: begin
        nx_tag   = st_tag;
        nx_otype = st_otype;
      end
      default: nx_tag = 1'b0;
    endcase
  end

  cpf_out_reg #(.W(RES_W)) or_i (
    .clk  (clk),
    .rst  (rst),
    .vld_i(in_valid),
    .d_i  ({nx_tag, nx_otype, nx_perms, cap_payload}),
    .vld_o(out_valid),
    .q_o  (res_q)
  );

  assign {out_tag, out_otype, out_perms, out_payload} = res_q;

  // R4
  weak_ld_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd0 && cap_tag && !auth_perms[BIT_TW] && !sealed_eff)
      |=> (out_tag && (out_perms & STORE_BITS) == '0))
    else $error("weak_ld_chk");

  // R6
  sealed_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd0 && cap_sealed && cap_otype != EPH_CODE)
      |=> (out_perms == $past(cap_perms)))
    else $error("sealed_keep_chk");

  // R9
  eph_store_detag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd1 && cap_otype == EPH_CODE) |=> !out_tag)
    else $error("eph_store_detag_chk");

  // R10
  eph_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'd2 && cap_tag && !cap_sealed && cap_otype != EPH_CODE)
      |=> (out_tag && out_otype == EPH_CODE))
    else $error("eph_mark_chk");

  // R7
  no_tag_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cap_tag) |=> !out_tag)
    else $error("no_tag_gain_chk");

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_tag) && $stable(out_payload)
                   && $stable(out_perms) && $stable(out_otype)))
    else $error("hold_chk");

  // R2
  payload_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid && out_payload == $past(cap_payload)))
    else $error("payload_pass_chk");
endmodule

// File: tb/cap_perm_filter_tb_top.sv
module cap_perm_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] STRIP = 12'h0B4;
  localparam logic [3:0]  EPH   = 4'd14;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op;
  logic [11:0] auth_perms;
  logic        cap_tag, cap_sealed;
  logic [3:0]  cap_otype;
  logic [11:0] cap_perms;
  logic [31:0] cap_payload;
  logic        out_valid, out_tag;
  logic [3:0]  out_otype;
  logic [11:0] out_perms;
  logic [31:0] out_payload;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_perm_filter dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .auth_perms(auth_perms), .cap_tag(cap_tag), .cap_sealed(cap_sealed),
    .cap_otype(cap_otype), .cap_perms(cap_perms), .cap_payload(cap_payload),
    .out_valid(out_valid), .out_tag(out_tag), .out_otype(out_otype),
    .out_perms(out_perms), .out_payload(out_payload)
  );

  task automatic check(string req, logic v, logic t, logic [3:0] ot,
                       logic [11:0] p, logic [31:0] pl);
    n_chk++;
    if (out_valid !== v || out_tag !== t || out_otype !== ot ||
        out_perms !== p || out_payload !== pl) begin
      n_bad++;
      $display("FAIL %s: got v=%0b t=%0b ot=%h p=%h pl=%h exp v=%0b t=%0b ot=%h p=%h pl=%h",
               req, out_valid, out_tag, out_otype, out_perms, out_payload,
               v, t, ot, p, pl);
    end
  endtask

  // drive at falling edge, capture at next rising edge, sample at following falling edge
  task automatic apply(logic [1:0] o, logic [11:0] a, logic t, logic s,
                       logic [3:0] ot, logic [11:0] p, logic [31:0] pl);
    in_valid = 1'b1; op = o; auth_perms = a; cap_tag = t;
    cap_sealed = s; cap_otype = ot; cap_perms = p; cap_payload = pl;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    // R1
    check("R1", 1'b0, 1'b0, 4'h0, 12'h000, 32'h0);
  endtask

  task automatic t_weaken();
    // R4 / R3: authorizer lacks bit 7
    apply(2'd0, 12'hF7F, 1'b1, 1'b0, 4'h3, 12'hFFF, 32'hDEAD_0001);
    check("R4", 1'b1, 1'b1, 4'h3, 12'hFFF & ~STRIP, 32'hDEAD_0001);
    apply(2'd0, 12'h000, 1'b1, 1'b0, 4'h0, 12'h0A5, 32'h0000_1234);
    check("R4", 1'b1, 1'b1, 4'h0, 12'h0A5 & ~STRIP, 32'h0000_1234);
  endtask

  task automatic t_keep_rml();
    // R5
    apply(2'd0, 12'h080, 1'b1, 1'b0, 4'h5, 12'hFFF, 32'hCAFE_0002);
    check("R5", 1'b1, 1'b1, 4'h5, 12'hFFF, 32'hCAFE_0002);
  endtask

  task automatic t_sealed();
    // R6
    apply(2'd0, 12'h000, 1'b1, 1'b1, 4'h7, 12'h0B4, 32'h5EA1_0003);
    check("R6", 1'b1, 1'b1, 4'h7, 12'h0B4, 32'h5EA1_0003);
  endtask

  task automatic t_untagged();
    // R7
    apply(2'd0, 12'h000, 1'b0, 1'b0, 4'h2, 12'hFFF, 32'h0000_0004);
    check("R7", 1'b1, 1'b0, 4'h2, 12'hFFF, 32'h0000_0004);
  endtask

  task automatic t_eph_load();
    // R8: ephemeral with sealed flag set is not exempt
    apply(2'd0, 12'h080, 1'b1, 1'b0, EPH, 12'hFFF, 32'hEEEE_0005);
    check("R8", 1'b1, 1'b1, EPH, 12'hFFF, 32'hEEEE_0005);
    apply(2'd0, 12'h000, 1'b1, 1'b1, EPH, 12'hFFF, 32'hEEEE_0006);
    check("R8", 1'b1, 1'b1, EPH, 12'hFFF & ~STRIP, 32'hEEEE_0006);
  endtask

  task automatic t_store();
    // R9
    apply(2'd1, 12'h000, 1'b1, 1'b0, EPH, 12'h3C3, 32'h0000_0007);
    check("R9", 1'b1, 1'b0, EPH, 12'h3C3, 32'h0000_0007);
    apply(2'd1, 12'h000, 1'b1, 1'b1, 4'h9, 12'h3C3, 32'h0000_0008);
    check("R9", 1'b1, 1'b1, 4'h9, 12'h3C3, 32'h0000_0008);
  endtask

  task automatic t_eph_store();
    // R10
    apply(2'd2, 12'h000, 1'b1, 1'b0, 4'h1, 12'h5A5, 32'h0000_0009);
    check("R10", 1'b1, 1'b1, EPH, 12'h5A5, 32'h0000_0009);
    // R11
    apply(2'd2, 12'h000, 1'b1, 1'b0, EPH, 12'h5A5, 32'h0000_000A);
    check("R11", 1'b1, 1'b0, EPH, 12'h5A5, 32'h0000_000A);
    apply(2'd2, 12'h000, 1'b1, 1'b1, 4'h4, 12'h5A5, 32'h0000_000B);
    check("R11", 1'b1, 1'b0, 4'h4, 12'h5A5, 32'h0000_000B);
    apply(2'd2, 12'h000, 1'b0, 1'b0, 4'h4, 12'h5A5, 32'h0000_000C);
    check("R11", 1'b1, 1'b0, 4'h4, 12'h5A5, 32'h0000_000C);
  endtask

  task automatic t_reserved();
    // R12
    apply(2'd3, 12'hFFF, 1'b1, 1'b0, 4'h6, 12'h111, 32'h0000_000D);
    check("R12", 1'b1, 1'b0, 4'h6, 12'h111, 32'h0000_000D);
  endtask

  task automatic t_hold();
    // R2: no strobe keeps last result, valid low
    apply(2'd0, 12'h080, 1'b1, 1'b0, 4'h8, 12'h777, 32'h0000_00EE);
    check("R2", 1'b1, 1'b1, 4'h8, 12'h777, 32'h0000_00EE);
    cap_payload = 32'hFFFF_FFFF; cap_perms = 12'h000; cap_tag = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2", 1'b0, 1'b1, 4'h8, 12'h777, 32'h0000_00EE);
    @(posedge clk); @(negedge clk);
    check("R2", 1'b0, 1'b1, 4'h8, 12'h777, 32'h0000_00EE);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = 2'd0; auth_perms = '0;
    cap_tag = 1'b0; cap_sealed = 1'b0; cap_otype = '0;
    cap_perms = '0; cap_payload = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_weaken();
    t_keep_rml();
    t_sealed();
    t_untagged();
    t_eph_load();
    t_store();
    t_eph_store();
    t_reserved();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule